// File: doc/BRIEF.md
# Sliding-Window Traffic Envelope Estimator

This block watches a stream of injected beats, one possible beat per clock, and estimates at run time a linear arrival-curve envelope for it: an average rate and a burstiness. The rate bounds long-run throughput. The burstiness is the largest amount by which the cumulative traffic runs ahead of the rate line inside a window. A flow regulator, such as a token bucket in front of a network port, can load these two numbers as its parameters.

Several window engines run at once. Their sampling windows are L = 2^LSW_LOG2 cycles long, and each engine starts P = L / 2^NENG_LOG2 cycles after the one before it, so the windows overlap. When an engine closes a window, it stores that window's beat pattern and then scans it. The scan uses no divider or multiplier: it keeps a running maximum of cumulative count times L minus cycle index times the window total. The engine that has just finished is selected, and a predictor extrapolates linearly from the previous result and this one. One update strobe comes out every P cycles.

Rate and burstiness are both unsigned fixed-point values with LSW_LOG2 fraction bits. A rate of L therefore means one beat per cycle, and a burstiness of L means one beat.

Top module: `flow_characterizer`

## Requirements
- R1: While en_i is held high, the first upd_o pulse, one cycle wide, comes 2L+1 cycles after the first enabled clock edge. Later pulses follow exactly every P cycles, with no other pulses in between.
- R2: The update whose upd_o is seen in enabled cycle n (cycles numbered from 0 at the first enabled edge) describes the window made of cycles n-2L-1 through n-L-2.
- R3: A window's current rate T is the number of beats in the window. It reads as T/L beats per cycle.
- R4: A window's current burstiness is the maximum over t = 0..L of f(t)*L - t*T, where f(t) counts the beats in the first t cycles of the window.
- R5: The output rate is 2*T - T_prev, and the output burstiness is 2*S - S_prev, where T_prev and S_prev come from the previous update. On the first update after enable, the previous values are taken equal to the current ones.
- R6: A rate prediction below zero comes out as zero.
- R7: A burstiness prediction below L (one beat) comes out as L.
- R8: While en_i is low, upd_o stays low and all window state is cleared. After en_i goes high again, the schedule and the prediction history start afresh.
- R9: After reset, upd_o, rho_o and sigma_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds every engine cleared |
| beat_i | input | 1 | One traffic beat in this cycle |
| upd_o | output | 1 | Pulse when a new estimate is presented |
| rho_o | output | LSW_LOG2+2 | Predicted rate, LSW_LOG2 fraction bits |
| sigma_o | output | 2*LSW_LOG2+1 | Predicted burstiness, LSW_LOG2 fraction bits |

## Verification
The hardest case to reach from the ports is the rate extrapolation going negative. Neighbouring windows differ by only P cycles, so the rate must fall steadily across several consecutive updates. The stimulus drives a long fully busy run followed by a long idle run, which walks the window totals down to zero while the previous total is still positive. Other segments use all-idle and all-busy traffic to reach the burstiness floor, and short periodic bursts to place the critical instant early in a window. Every segment starts with a fresh enable, so the first-update rule and the restart after disable are checked again each time.

// File: rtl/flow_char_pkg.sv
package flow_char_pkg;
  function automatic int cnt_w(int lw);
    return lw + 1;
  endfunction
  function automatic int rate_w(int lw);
    return lw + 2;
  endfunction
  function automatic int burst_w(int lw);
    return 2 * lw;
  endfunction
  function automatic int pburst_w(int lw);
    return 2 * lw + 1;
  endfunction
endpackage

// File: rtl/fc_window_engine.sv
module fc_window_engine
  import flow_char_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   start_i,
  input  logic                   beat_i,
  output logic                   done_o,
  output logic [cnt_w(LW)-1:0]   rho_o,
  output logic [burst_w(LW)-1:0] sigma_o
);
  localparam int L  = 1 << LW;
  localparam int CW = cnt_w(LW);
  localparam int SW = burst_w(LW);
  localparam int AW = 2 * LW + 2;

  logic          running_q, scan_q;
  logic [LW-1:0] idx_q, spos_q;
  logic [L-1:0]  bits_q, shadow_q, bits_full;
  logic [CW-1:0] cnt_q, total_q;
  logic signed [AW-1:0] acc_q, max_q, acc_nx, max_nx, step_up, step_dn;
  logic act, last;

  assign act  = en_i & (running_q | start_i);
  assign last = act & (idx_q == LW'(L - 1));

  always_comb begin
    bits_full         = bits_q;
    bits_full[idx_q]  = beat_i;
    step_up = shadow_q[spos_q] ? AW'(L) : '0;
    step_dn = AW'(total_q);
    acc_nx  = acc_q + step_up - step_dn;
    max_nx  = (acc_nx > max_q) ? acc_nx : max_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0; scan_q <= 1'b0; done_o <= 1'b0;
      idx_q <= '0; spos_q <= '0; bits_q <= '0; shadow_q <= '0;
      cnt_q <= '0; total_q <= '0; acc_q <= '0; max_q <= '0;
      rho_o <= '0; sigma_o <= '0;
    end else if (!en_i) begin
      running_q <= 1'b0; scan_q <= 1'b0; done_o <= 1'b0;
      idx_q <= '0; spos_q <= '0; cnt_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (act) begin
        running_q     <= 1'b1;
        bits_q[idx_q] <= beat_i;
        idx_q         <= idx_q + 1'b1;
        cnt_q         <= last ? '0 : cnt_q + CW'(beat_i);
      end
      if (scan_q) begin
        acc_q  <= acc_nx;
        max_q  <= max_nx;
        spos_q <= spos_q + 1'b1;
        if (spos_q == LW'(L - 1)) begin
          scan_q  <= 1'b0;
          done_o  <= 1'b1;
          rho_o   <= total_q;
          sigma_o <= SW'(max_nx);
        end
      end
      // a closing window takes over the scanner on the same edge the previous scan ends
      if (last) begin
        shadow_q <= bits_full;
        total_q  <= cnt_q + CW'(beat_i);
        scan_q   <= 1'b1;
        spos_q   <= '0;
        acc_q    <= '0;
        max_q    <= '0;
      end
    end
  end

  AST_RATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rho_o <= CW'(L)); // R3
  AST_SCAN_ENDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_q && en_i && spos_q == LW'(L - 1)) |-> acc_nx == '0); // R4
endmodule

// File: rtl/fc_predictor.sv
module fc_predictor
  import flow_char_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    done_i,
  input  logic [cnt_w(LW)-1:0]    rho_i,
  input  logic [burst_w(LW)-1:0]  sigma_i,
  output logic                    upd_o,
  output logic [rate_w(LW)-1:0]   rho_o,
  output logic [pburst_w(LW)-1:0] sigma_o
);
  localparam int L   = 1 << LW;
  localparam int CW  = cnt_w(LW);
  localparam int SW  = burst_w(LW);
  localparam int RW  = rate_w(LW);
  localparam int PSW = pburst_w(LW);

  logic          have_prev_q;
  logic [CW-1:0] prev_rho_q;
  logic [SW-1:0] prev_sig_q;
  logic signed [RW:0]  r_cur, r_prv, r_ext;
  logic signed [PSW:0] s_cur, s_prv, s_ext;
  logic [RW-1:0]  rho_pred;
  logic [PSW-1:0] sig_pred;

  always_comb begin
    r_cur = (RW+1)'(rho_i);
    r_prv = have_prev_q ? (RW+1)'(prev_rho_q) : r_cur;
    r_ext = (r_cur <<< 1) - r_prv;
    s_cur = (PSW+1)'(sigma_i);
    s_prv = have_prev_q ? (PSW+1)'(prev_sig_q) : s_cur;
    s_ext = (s_cur <<< 1) - s_prv;
    rho_pred = (r_ext < 0) ? '0 : r_ext[RW-1:0];
    sig_pred = (s_ext < (PSW+1)'(L)) ? PSW'(L) : s_ext[PSW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o <= 1'b0; have_prev_q <= 1'b0;
      prev_rho_q <= '0; prev_sig_q <= '0;
      rho_o <= '0; sigma_o <= '0;
    end else if (!en_i) begin
      upd_o <= 1'b0; have_prev_q <= 1'b0;
    end else begin
      upd_o <= done_i;
      if (done_i) begin
        rho_o       <= rho_pred;
        sigma_o     <= sig_pred;
        prev_rho_q  <= rho_i;
        prev_sig_q  <= sigma_i;
        have_prev_q <= 1'b1;
      end
    end
  end

  AST_BURST_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> sigma_o >= PSW'(L)); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !upd_o); // R8
  AST_RATE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> rho_o <= RW'(2 * L)); // R6
endmodule

// File: rtl/flow_characterizer.sv
module flow_characterizer
  import flow_char_pkg::*;
#(
  parameter int LSW_LOG2  = 4,
  parameter int NENG_LOG2 = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          beat_i,
  output logic                          upd_o,
  output logic [rate_w(LSW_LOG2)-1:0]   rho_o,
  output logic [pburst_w(LSW_LOG2)-1:0] sigma_o
);
  localparam int LW  = LSW_LOG2;
  localparam int NE  = 1 << NENG_LOG2;
  localparam int LPW = (1 << LW) / NE;
  localparam int CW  = cnt_w(LW);
  localparam int SW  = burst_w(LW);

  logic [LW-1:0] phase_q;
  logic [NE-1:0] done;
  logic [CW-1:0] eng_rho [NE];
  logic [SW-1:0] eng_sig [NE];
  logic [CW-1:0] sel_rho;
  logic [SW-1:0] sel_sig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (!en_i) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  for (genvar k = 0; k < NE; k++) begin : g_eng
    fc_window_engine #(.LW(LW)) i_eng (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .start_i (phase_q == LW'(k * LPW)),
      .beat_i  (beat_i),
      .done_o  (done[k]),
      .rho_o   (eng_rho[k]),
      .sigma_o (eng_sig[k])
    );
  end

  always_comb begin
    sel_rho = '0;
    sel_sig = '0;
    for (int k = 0; k < NE; k++) begin
      if (done[k]) begin
        sel_rho = eng_rho[k];
        sel_sig = eng_sig[k];
      end
    end
  end

  fc_predictor #(.LW(LW)) i_pred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .done_i  (|done),
    .rho_i   (sel_rho),
    .sigma_i (sel_sig),
    .upd_o   (upd_o),
    .rho_o   (rho_o),
    .sigma_o (sigma_o)
  );

  // spacing monitor
  logic [LW:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; seen_q <= 1'b0;
    end else if (!en_i) begin
      gap_q <= '0; seen_q <= 1'b0;
    end else if (upd_o) begin
      gap_q <= '0; seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_ONE_ENGINE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done)); // R1
  AST_UPDATE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && seen_q && en_i) |-> gap_q == (LW+1)'(LPW - 1)); // R1
endmodule

// File: tb/test_flow_characterizer.sv
module test_flow_characterizer;
  localparam int LW  = 4;
  localparam int NL  = 2;
  localparam int L   = 1 << LW;
  localparam int LPW = L >> NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic beat = 1'b0;
  logic upd;
  logic [LW+1:0] rho;
  logic [2*LW:0] sigma;

  int checks = 0;
  int errors = 0;
  int bt [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flow_characterizer #(.LSW_LOG2(LW), .NENG_LOG2(NL)) i_flow_characterizer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .beat_i(beat),
    .upd_o(upd), .rho_o(rho), .sigma_o(sigma)
  );

  function automatic int pattern(int mode, int c, logic [15:0] lf);
    case (mode)
      0: return 0;
      1: return 1;
      2: return ((c % 32) < 5) ? 1 : 0;
      3: return int'(lf[0]);
      4: return (c < 60) ? 1 : 0;
      5: return ((c % 3) == 0) ? 1 : 0;
      default: return (c < 24 || (c > 90 && c < 100)) ? 1 : 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_segment(input int mode, input int ncyc);
    bit have = 1'b0;
    longint prv_r = 0, prv_s = 0;
    @(negedge clk);
    en = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      bit exp_upd;
      if (n > 0) @(negedge clk);
      exp_upd = (n >= 2*L+1) && (((n - 2*L - 1) % LPW) == 0);
      chk(upd == exp_upd, "R1 upd timing", longint'(upd), longint'(exp_upd));
      if (exp_upd && upd) begin
        int st = n - 2*L - 1; // R2 window start
        longint tot = 0, f = 0, mx = 0, er, es, m;
        for (int t = 0; t < L; t++) tot += bt[st+t];
        for (int t = 1; t <= L; t++) begin
          f += bt[st+t-1];
          m = f*L - longint'(t)*tot;
          if (m > mx) mx = m;
        end
        er = have ? 2*tot - prv_r : tot;
        es = have ? 2*mx - prv_s : mx;
        if (er < 0) begin
          er = 0;
          chk(longint'(rho) == er, "R6 rate clamp", longint'(rho), er);
        end else if (!have) begin
          chk(longint'(rho) == er, "R5 first rate", longint'(rho), er);
        end else begin
          chk(longint'(rho) == er, "R2 R3 rate", longint'(rho), er);
        end
        if (es < L) begin
          es = L;
          chk(longint'(sigma) == es, "R7 burst floor", longint'(sigma), es);
        end else begin
          chk(longint'(sigma) == es, "R4 burst", longint'(sigma), es);
        end
        prv_r = tot; prv_s = mx; have = 1'b1;
      end
      beat = pattern(mode, n, lfsr) != 0;
      bt[n] = int'(beat);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    @(negedge clk);
    en = 1'b0;
    beat = 1'b1;
    for (int n = 0; n < 3*L; n++) begin
      @(negedge clk);
      if (n > 0) chk(upd == 1'b0, "R8 quiet while off", longint'(upd), 0);
    end
    beat = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(upd == 1'b0, "R9 reset upd", longint'(upd), 0);
    chk(rho == '0, "R9 reset rho", longint'(rho), 0);
    chk(sigma == '0, "R9 reset sigma", longint'(sigma), 0);
    rst_n = 1'b1;
    for (int mode = 0; mode < 7; mode++) run_segment(mode, 8*L + 40);
    // short enable, disabled mid-window, then a fresh run
    run_segment(3, L + 5);
    run_segment(2, 10*L);
    done_run = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!done_run && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule